// File: doc/BRIEF.md
# GPIO Pin Event Controller

This block is a general-purpose I/O peripheral for a set of pins (32 by default), reached through a plain memory-mapped register port. The port has an address, a write strobe, write data and a combinational read-data return. Each pin has its own controls:

- an input gate;
- an output drive enable;
- a driven level;
- an inversion bit that flips the driven level before it reaches the pad.

Incoming pin levels pass through a two-stage synchronizer. They are then masked by the input gate. The masked value feeds four per-pin event detectors: level high, level low, rising change and falling change. Each event kind has an enable word and a sticky pending word. Software clears a pending bit by writing a one to it. A single interrupt line leaves the block toward an external interrupt controller. It is raised whenever any pending bit meets its enable.

Two alternate-function words are kept as plain storage. Software can read them back, but they do not steer the pins. Offsets that decode to no register read as zero and accept writes without effect.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset every register reads zero, except the low-level pending word, which reads all ones. The pins drive zero with the output enable low.
- R2: The input-value word reads the pin level through two synchronizer flops, ANDed with the input gate. A bit whose gate is clear reads zero. A change at a pin becomes visible in a read two clock edges after it is sampled.
- R3: Each pin drives (output level XOR inversion mask). The pad enable equals the output-enable word.
- R4: A high pending bit sets on every clock edge where its gated input is 1. A low pending bit sets where the gated input is 0. Both stay set until cleared.
- R5: A rise pending bit sets when the gated input is 1 and was 0 on the previous cycle. A fall pending bit sets on the opposite change. Both are sticky.
- R6: Writing a 1 to a pending bit clears it. If the setting condition holds on the same edge, the set wins.
- R7: The interrupt output is the OR, over all pins and all four event kinds, of pending AND enable. Enabling an event whose pending bit is clear does not raise it.
- R8: The two alternate-function words read back what was written and change neither pin drive nor pad enable.
- R9: Reads of an undecoded offset return zero, and writes to one alter no register.
- R10: Register offsets (bytes) are as follows.
  - Inversion mask: 0x40.
  - Input gate 0x04, input value 0x00.
  - Output level 0x0C, output enable 0x08.
  - Enable/pending pairs: rise 0x18/0x1C, fall 0x20/0x24, high 0x28/0x2C, low 0x30/0x34.
  - Alternate-function enable 0x38, select 0x3C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 7 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, register updates on the clock edge |
| bus_wdata | input | PIN_CNT | Write data |
| bus_rdata | output | PIN_CNT | Read data for bus_addr, combinational |
| pin_in | input | PIN_CNT | Asynchronous pin levels |
| pin_out | output | PIN_CNT | Pin drive level after inversion |
| pin_oe | output | PIN_CNT | Pad output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench loops the pins back and checks the values a sticky design must hold. One case is the change of gated input from 0xA55A0000 to 0xA4AA0000. After it, a non-sticky level detector would drop bits that are still pending, and an edge detector looking at raw rather than gated pins would report changes on gated-off pins. The bench clears a high pending word while its input is still high. A design that let the clear win would read zero instead of the live level. The bench also enables events whose pending bit is clear, and expects no interrupt. The behavioural model runs against randomly driven pins and register writes, including undecoded offsets. It catches an off-by-one in synchronizer latency and a missing reset-to-ones on the low pending word.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

    localparam int unsigned ADDR_W = 7;
    localparam int unsigned NUM_EV = 4;

    // event kind indices
    localparam int unsigned EV_RISE = 0;
    localparam int unsigned EV_FALL = 1;
    localparam int unsigned EV_HIGH = 2;
    localparam int unsigned EV_LOW  = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_IN_VAL    = 7'h00,
        OFS_IN_EN     = 7'h04,
        OFS_OUT_EN    = 7'h08,
        OFS_OUT_VAL   = 7'h0C,
        OFS_RISE_EN   = 7'h18,
        OFS_RISE_PEND = 7'h1C,
        OFS_FALL_EN   = 7'h20,
        OFS_FALL_PEND = 7'h24,
        OFS_HIGH_EN   = 7'h28,
        OFS_HIGH_PEND = 7'h2C,
        OFS_LOW_EN    = 7'h30,
        OFS_LOW_PEND  = 7'h34,
        OFS_ALT_EN    = 7'h38,
        OFS_ALT_SEL   = 7'h3C,
        OFS_INVERT    = 7'h40
    } reg_ofs_e;

    function automatic logic [ADDR_W-1:0] ev_en_ofs(input int unsigned ev);
        case (ev)
            EV_RISE: return OFS_RISE_EN;
            EV_FALL: return OFS_FALL_EN;
            EV_HIGH: return OFS_HIGH_EN;
            default: return OFS_LOW_EN;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] ev_pend_ofs(input int unsigned ev);
        case (ev)
            EV_RISE: return OFS_RISE_PEND;
            EV_FALL: return OFS_FALL_PEND;
            EV_HIGH: return OFS_HIGH_PEND;
            default: return OFS_LOW_PEND;
        endcase
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
    import pin_event_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [W-1:0]             sync_in,
    input  logic [W-1:0]             in_gate,
    output logic [W-1:0]             gated,
    output logic [NUM_EV-1:0][W-1:0] cond
);

    logic [W-1:0] prev_q;

    assign gated = sync_in & in_gate;

    // previous-cycle copy of the gated value for change detection
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= gated;
        end
    end

    always_comb begin
        cond[EV_RISE] = gated & ~prev_q;
        cond[EV_FALL] = ~gated & prev_q;
        cond[EV_HIGH] = gated;
        cond[EV_LOW]  = ~gated;
    end

endmodule

// File: rtl/pin_pending_bank.sv
module pin_pending_bank #(
    parameter int unsigned W          = 32,
    parameter bit          RESET_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pend_clr,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pend_q,
    output logic         hit
);

    localparam logic [W-1:0] PEND_RST = RESET_ONES ? {W{1'b1}} : {W{1'b0}};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_we) begin
            en_q <= wdata;
        end
    end

    // set has priority over a write-one clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= PEND_RST;
        end else begin
            pend_q <= (pend_q & ~pend_clr) | set_vec;
        end
    end

    assign hit = |(pend_q & en_q);

endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
    import pin_event_pkg::*;
#(
    parameter int unsigned PIN_CNT = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [PIN_CNT-1:0] bus_wdata,
    output logic [PIN_CNT-1:0] bus_rdata,
    input  logic [PIN_CNT-1:0] pin_in,
    output logic [PIN_CNT-1:0] pin_out,
    output logic [PIN_CNT-1:0] pin_oe,
    output logic               irq
);

    logic [PIN_CNT-1:0] in_en_q;
    logic [PIN_CNT-1:0] out_en_q;
    logic [PIN_CNT-1:0] out_val_q;
    logic [PIN_CNT-1:0] invert_q;
    logic [PIN_CNT-1:0] alt_en_q;
    logic [PIN_CNT-1:0] alt_sel_q;

    logic [PIN_CNT-1:0]              sync_q;
    logic [PIN_CNT-1:0]              gated;
    logic [NUM_EV-1:0][PIN_CNT-1:0]  cond;
    logic [NUM_EV-1:0][PIN_CNT-1:0]  en_vec;
    logic [NUM_EV-1:0][PIN_CNT-1:0]  pend_vec;
    logic [NUM_EV-1:0]               hit;

    // plain configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            in_en_q   <= '0;
            out_en_q  <= '0;
            out_val_q <= '0;
            invert_q  <= '0;
            alt_en_q  <= '0;
            alt_sel_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_IN_EN:   in_en_q   <= bus_wdata;
                OFS_OUT_EN:  out_en_q  <= bus_wdata;
                OFS_OUT_VAL: out_val_q <= bus_wdata;
                OFS_INVERT:  invert_q  <= bus_wdata;
                OFS_ALT_EN:  alt_en_q  <= bus_wdata;
                OFS_ALT_SEL: alt_sel_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign pin_out = out_val_q ^ invert_q;
    assign pin_oe  = out_en_q;

    pin_sync #(.W(PIN_CNT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_q)
    );

    pin_event_detect #(.W(PIN_CNT)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_q),
        .in_gate (in_en_q),
        .gated   (gated),
        .cond    (cond)
    );

    for (genvar e = 0; e < NUM_EV; e++) begin : g_event
        localparam logic [ADDR_W-1:0] EN_OFS   = ev_en_ofs(e);
        localparam logic [ADDR_W-1:0] PEND_OFS = ev_pend_ofs(e);

        logic               en_we;
        logic [PIN_CNT-1:0] clr;

        assign en_we = bus_wr && (bus_addr == EN_OFS);
        assign clr   = (bus_wr && (bus_addr == PEND_OFS)) ? bus_wdata : '0;

        pin_pending_bank #(
            .W          (PIN_CNT),
            .RESET_ONES (e == EV_LOW)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .en_we    (en_we),
            .wdata    (bus_wdata),
            .pend_clr (clr),
            .set_vec  (cond[e]),
            .en_q     (en_vec[e]),
            .pend_q   (pend_vec[e]),
            .hit      (hit[e])
        );
    end

    assign irq = |hit;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_IN_VAL:    bus_rdata = gated;
            OFS_IN_EN:     bus_rdata = in_en_q;
            OFS_OUT_EN:    bus_rdata = out_en_q;
            OFS_OUT_VAL:   bus_rdata = out_val_q;
            OFS_RISE_EN:   bus_rdata = en_vec[EV_RISE];
            OFS_RISE_PEND: bus_rdata = pend_vec[EV_RISE];
            OFS_FALL_EN:   bus_rdata = en_vec[EV_FALL];
            OFS_FALL_PEND: bus_rdata = pend_vec[EV_FALL];
            OFS_HIGH_EN:   bus_rdata = en_vec[EV_HIGH];
            OFS_HIGH_PEND: bus_rdata = pend_vec[EV_HIGH];
            OFS_LOW_EN:    bus_rdata = en_vec[EV_LOW];
            OFS_LOW_PEND:  bus_rdata = pend_vec[EV_LOW];
            OFS_ALT_EN:    bus_rdata = alt_en_q;
            OFS_ALT_SEL:   bus_rdata = alt_sel_q;
            OFS_INVERT:    bus_rdata = invert_q;
            default:       bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pin_event_ctrl_chk.sv
module pin_event_ctrl_chk
    import pin_event_pkg::*;
#(
    parameter int unsigned PIN_CNT = 32
) (
    input logic                            clk,
    input logic                            rst,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic                            bus_wr,
    input logic [PIN_CNT-1:0]              bus_wdata,
    input logic [PIN_CNT-1:0]              bus_rdata,
    input logic [PIN_CNT-1:0]              pin_out,
    input logic [PIN_CNT-1:0]              pin_oe,
    input logic                            irq,
    input logic [PIN_CNT-1:0]              in_gate,
    input logic [PIN_CNT-1:0]              inv_mask,
    input logic [NUM_EV-1:0][PIN_CNT-1:0]  pend
);

    logic mapped;
    logic touches_irq;

    always_comb begin
        mapped = bus_addr inside {OFS_IN_VAL, OFS_IN_EN, OFS_OUT_EN, OFS_OUT_VAL,
                                  OFS_RISE_EN, OFS_RISE_PEND, OFS_FALL_EN, OFS_FALL_PEND,
                                  OFS_HIGH_EN, OFS_HIGH_PEND, OFS_LOW_EN, OFS_LOW_PEND,
                                  OFS_ALT_EN, OFS_ALT_SEL, OFS_INVERT};
        touches_irq = bus_wr && (bus_addr inside {OFS_RISE_EN, OFS_RISE_PEND, OFS_FALL_EN,
                                  OFS_FALL_PEND, OFS_HIGH_EN, OFS_HIGH_PEND,
                                  OFS_LOW_EN, OFS_LOW_PEND});
    end

    AST_OE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_OUT_EN) |=> (pin_oe == $past(bus_wdata))); // R3

    AST_INVERT_FLIPS_PINS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_INVERT)
        |=> ((pin_out ^ $past(pin_out)) == ($past(bus_wdata) ^ $past(inv_mask)))); // R3

    AST_GATED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_IN_VAL) |-> ((bus_rdata & ~in_gate) == '0)); // R2

    AST_RISE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFS_RISE_PEND) |=> (($past(pend[EV_RISE]) & ~pend[EV_RISE]) == '0)); // R5

    AST_FALL_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFS_FALL_PEND) |=> (($past(pend[EV_FALL]) & ~pend[EV_FALL]) == '0)); // R5

    AST_HIGH_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFS_HIGH_PEND) |=> (($past(pend[EV_HIGH]) & ~pend[EV_HIGH]) == '0)); // R4

    AST_LOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFS_LOW_PEND) |=> (($past(pend[EV_LOW]) & ~pend[EV_LOW]) == '0)); // R4

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq && !touches_irq) |=> irq); // R7

    AST_ALT_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == OFS_ALT_EN || bus_addr == OFS_ALT_SEL))
        |=> ($stable(pin_out) && $stable(pin_oe))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (bus_rdata == '0)); // R9

endmodule

bind pin_event_ctrl pin_event_ctrl_chk #(.PIN_CNT(PIN_CNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .in_gate   (in_en_q),
    .inv_mask  (invert_q),
    .pend      (pend_vec)
);

// File: tb/pin_event_ctrl_tb.sv
module pin_event_ctrl_tb;

    localparam logic [6:0] A_IN = 7'h00, A_INEN = 7'h04, A_OEN = 7'h08, A_OVAL = 7'h0C;
    localparam logic [6:0] A_ALTE = 7'h38, A_ALTS = 7'h3C, A_XOR = 7'h40;
    // event order: rise, fall, high, low
    localparam logic [6:0] A_IE [4] = '{7'h18, 7'h20, 7'h28, 7'h30};
    localparam logic [6:0] A_IP [4] = '{7'h1C, 7'h24, 7'h2C, 7'h34};
    localparam logic [6:0] ALL_A [17] = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h18, 7'h1C, 7'h20,
        7'h24, 7'h28, 7'h2C, 7'h30, 7'h34, 7'h38, 7'h3C, 7'h40, 7'h10, 7'h44};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit loop_mode = 1'b1;
    logic [31:0] ext_pins = '0;

    always #5 clk = ~clk;

    pin_event_ctrl #(.PIN_CNT(32)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_inen, m_oen, m_oval, m_xor, m_alte, m_alts, m_prev;
    logic [31:0] m_ie [4];
    logic [31:0] m_ip [4];
    logic [31:0] m_pipe [$];

    function automatic logic [31:0] m_read(input logic [6:0] a);
        logic [31:0] r;
        r = '0;
        for (int e = 0; e < 4; e++) begin
            if (a == A_IE[e]) r = m_ie[e];
            if (a == A_IP[e]) r = m_ip[e];
        end
        if (a == A_IN)   r = m_pipe[1] & m_inen;
        if (a == A_INEN) r = m_inen;
        if (a == A_OEN)  r = m_oen;
        if (a == A_OVAL) r = m_oval;
        if (a == A_ALTE) r = m_alte;
        if (a == A_ALTS) r = m_alts;
        if (a == A_XOR)  r = m_xor;
        return r;
    endfunction

    function automatic logic m_irq();
        logic r;
        r = 1'b0;
        for (int e = 0; e < 4; e++) r = r | (|(m_ip[e] & m_ie[e]));
        return r;
    endfunction

    always @(posedge clk) begin
        logic [31:0] g;
        logic [31:0] clr;
        logic [31:0] cnd [4];
        if (rst) begin
            m_inen = '0; m_oen = '0; m_oval = '0; m_xor = '0;
            m_alte = '0; m_alts = '0; m_prev = '0;
            for (int e = 0; e < 4; e++) begin m_ie[e] = '0; m_ip[e] = '0; end
            m_ip[3] = '1;
            m_pipe = '{32'h0, 32'h0};
        end else begin
            g = m_pipe[1] & m_inen;
            cnd[0] = g & ~m_prev;
            cnd[1] = ~g & m_prev;
            cnd[2] = g;
            cnd[3] = ~g;
            for (int e = 0; e < 4; e++) begin
                clr = (bus_wr && bus_addr == A_IP[e]) ? bus_wdata : 32'h0;
                m_ip[e] = (m_ip[e] & ~clr) | cnd[e];
            end
            m_prev = g;
            m_pipe.push_front(pin_in);
            void'(m_pipe.pop_back());
            if (bus_wr) begin
                for (int e = 0; e < 4; e++) if (bus_addr == A_IE[e]) m_ie[e] = bus_wdata;
                if (bus_addr == A_INEN) m_inen = bus_wdata;
                if (bus_addr == A_OEN)  m_oen  = bus_wdata;
                if (bus_addr == A_OVAL) m_oval = bus_wdata;
                if (bus_addr == A_ALTE) m_alte = bus_wdata;
                if (bus_addr == A_ALTS) m_alts = bus_wdata;
                if (bus_addr == A_XOR)  m_xor  = bus_wdata;
            end
        end
    end

    // pin stimulus: loopback of expected drive or external pattern
    always @(negedge clk) begin
        pin_in <= loop_mode ? (m_oval ^ m_xor) : ext_pins;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            #3;
            chk("R3 pin drive vs model", pin_out, m_oval ^ m_xor);
            chk("R3 pad enable vs model", pin_oe, m_oen);
            chk("R7 irq vs model", {31'h0, irq}, {31'h0, m_irq()});
            chk("R10 read data vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        idle(4);
        rst = 1'b0;

        // R1 R10: reset values at every offset
        for (int i = 0; i < 15; i++)
            rd_chk(ALL_A[i], (ALL_A[i] == 7'h34) ? 32'hFFFFFFFF : 32'h0, "R1 R10 reset value");
        #1 chk("R1 reset pin drive", pin_out, 32'h0);
        chk("R1 reset pad enable", pin_oe, 32'h0);

        // R2 R3: loopback reads
        wr_reg(A_OEN, 32'hFFFFFFFF);
        wr_reg(A_OVAL, 32'hA5A5A5A5);
        wr_reg(A_INEN, 32'hFFFFFFFF);
        idle(3);
        rd_chk(A_IN, 32'hA5A5A5A5, "R2 loopback read");
        chk("R3 pad enable", pin_oe, 32'hFFFFFFFF);

        // R2 two-edge latency
        wr_reg(A_OVAL, 32'h5A5AFFFF);
        rd_chk(A_IN, 32'hA5A5A5A5, "R2 old value one edge after change");
        idle(2);
        rd_chk(A_IN, 32'h5A5AFFFF, "R2 new value after sync");

        wr_reg(A_INEN, 32'h0);
        rd_chk(A_IN, 32'h0, "R2 gate closed");
        wr_reg(A_INEN, 32'hFFFF0000);
        rd_chk(A_IN, 32'h5A5A0000, "R2 partial gate");

        // R3 inversion
        wr_reg(A_XOR, 32'hFF00FF00);
        idle(3);
        rd_chk(A_IN, 32'hA55A0000, "R3 inverted loopback");
        chk("R3 pin drive inverted", pin_out, 32'hA55A00FF);

        // R6 clear all pending; level kinds re-set at once
        for (int e = 0; e < 4; e++) wr_reg(A_IP[e], 32'hFFFFFFFF);
        rd_chk(A_IP[2], 32'hA55A0000, "R6 high re-set after clear");
        rd_chk(A_IP[3], 32'h5AA5FFFF, "R6 low re-set after clear");
        rd_chk(A_IP[0], 32'h0, "R6 rise cleared");
        rd_chk(A_IP[1], 32'h0, "R6 fall cleared");

        // R4 R5: change of gated input 0xA55A0000 -> 0xA4AA0000
        wr_reg(A_OVAL, 32'h5BAA000F);
        idle(4);
        rd_chk(A_IN, 32'hA4AA0000, "R2 new gated value");
        rd_chk(A_IP[2], 32'hA5FA0000, "R4 high sticky");
        rd_chk(A_IP[3], 32'h5BF5FFFF, "R4 low sticky");
        rd_chk(A_IP[0], 32'h00A00000, "R5 rise");
        rd_chk(A_IP[1], 32'h01500000, "R5 fall");
        chk("R7 no enables no irq", {31'h0, irq}, 32'h0);

        // R7 enabling on clear pending bits
        wr_reg(A_IE[2], 32'h00010000); #1 chk("R7 high enable quiet", {31'h0, irq}, 32'h0);
        wr_reg(A_IE[3], 32'h00020000); #1 chk("R7 low enable quiet", {31'h0, irq}, 32'h0);
        wr_reg(A_IE[0], 32'h00010000); #1 chk("R7 rise enable quiet", {31'h0, irq}, 32'h0);
        wr_reg(A_IE[1], 32'h00010000); #1 chk("R7 fall enable quiet", {31'h0, irq}, 32'h0);
        wr_reg(A_IE[2], 32'h00020000); #1 chk("R7 high pending raises", {31'h0, irq}, 32'h1);
        wr_reg(A_IE[2], 32'h0);        #1 chk("R7 disable drops", {31'h0, irq}, 32'h0);
        wr_reg(A_IE[1], 32'h01000000); #1 chk("R7 fall pending raises", {31'h0, irq}, 32'h1);
        wr_reg(A_IP[1], 32'h01000000); #1 chk("R6 edge clear drops irq", {31'h0, irq}, 32'h0);
        rd_chk(A_IP[1], 32'h00500000, "R6 only written bit cleared");
        wr_reg(A_IP[2], 32'hFFFFFFFF);
        rd_chk(A_IP[2], 32'hA4AA0000, "R6 set wins over clear");

        // R8 alternate-function storage
        wr_reg(A_ALTE, 32'h12345678);
        wr_reg(A_ALTS, 32'h9ABCDEF0);
        rd_chk(A_ALTE, 32'h12345678, "R8 alt enable readback");
        rd_chk(A_ALTS, 32'h9ABCDEF0, "R8 alt select readback");
        chk("R8 pins unchanged", pin_out, 32'hA4AAFF0F);
        chk("R8 pad enable unchanged", pin_oe, 32'hFFFFFFFF);

        // R9 undecoded offsets
        wr_reg(7'h10, 32'hDEADBEEF);
        rd_chk(7'h10, 32'h0, "R9 undecoded read");
        rd_chk(7'h44, 32'h0, "R9 undecoded read high");
        rd_chk(A_OVAL, 32'h5BAA000F, "R9 write ignored");

        // random phase checked by the model every cycle
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 199) == 0) loop_mode = ~loop_mode;
            if ($urandom_range(0, 7) == 0) ext_pins = $urandom;
            bus_addr = ALL_A[$urandom_range(0, 16)];
            bus_wr = ($urandom_range(0, 3) == 0);
            bus_wdata = $urandom;
        end
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
        finish_run();
    end

endmodule